// File: doc/BRIEF.md
# Way-Predicting Two-Way Cache Lookup

This block is the lookup and control path of a two-way set-associative read cache. Every set carries one prediction bit that names the way expected to hold the requested block. On the first lookup cycle the output data mux is already steered to the predicted way, and a single tag comparator checks only that way. A correct guess returns the word one cycle after the request is accepted. A wrong guess costs two more cycles: the same comparator checks the other way in the next cycle, and a match there is delivered in the cycle after that.

When neither way matches, the controller asks the lower memory for the whole block and waits for an acknowledge. It writes the returned block into the way that was not predicted, points the prediction bit at that way, and then returns the requested word marked as a miss. Only one request is in flight at a time. The processor side may present a new request only while the controller is idle.

Top module: `wp_cache`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `mem_req` are 0, every line is invalid, and every set predicts way 0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle until the response cycle, `req_ready` is 0, and `req_valid` and `req_addr` are ignored.
- R3: If the predicted way holds a valid line with a matching tag, `rsp_valid` and `rsp_hit` are 1 in the first cycle after acceptance.
- R4: If only the non-predicted way matches, `rsp_valid` and `rsp_hit` are 1 in the third cycle after acceptance, and not before.
- R5: A hit in the non-predicted way switches that set's prediction to that way, so the next access to the same block hits in one cycle.
- R6: If neither way matches, `mem_req` rises in the third cycle after acceptance. `mem_addr` equals `req_addr[31:4]`, and both stay steady until the cycle in which `mem_ack` is 1.
- R7: `mem_data` is taken in the cycle where `mem_req` and `mem_ack` are both 1. The block goes into the non-predicted way, the set's prediction points to that way, and in the next cycle `rsp_valid` is 1 with `rsp_hit` 0.
- R8: The address splits into tag `[31:10]`, set index `[9:4]` and byte offset `[3:0]`. `rsp_data` is the 32-bit word `[w*32 +: 32]` of the block, where w = `req_addr[3:2]`.
- R9: A miss never evicts the predicted way, even when that way is invalid. After reset, the first miss in a set fills way 1 and the second miss fills way 0.
- R10: `req_ready` is 1 again in the cycle after every response.
- R11: `mem_ack` has no effect unless `mem_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 32 | Byte address of the request |
| req_ready | output | 1 | Controller idle, request can be taken |
| rsp_valid | output | 1 | Response word valid this cycle |
| rsp_hit | output | 1 | Response came from the cache, not from a refill |
| rsp_data | output | 32 | Response word |
| mem_req | output | 1 | Block fetch request to lower memory |
| mem_addr | output | 28 | Block address of the fetch |
| mem_ack | input | 1 | Lower memory returns the block this cycle |
| mem_data | input | 128 | Returned block, word 0 in the low bits |

## Verification
A corrupted prediction bit never returns wrong data. It only moves a hit between the one-cycle and three-cycle slots, so the bench compares latency on every access and catches the error at the next access to that set. Wrong victim choice or a wrong tag or valid write shows up later, as an unexpected miss or a skipped refill on a block the reference model still holds. The model therefore tracks every line and every prediction bit, and it checks `rsp_valid`, `rsp_hit`, `mem_req` and `req_ready` in each cycle of each access.

// File: rtl/wp_cache_pkg.sv
package wp_cache_pkg;

    // Controller phases of one access
    typedef enum logic [2:0] {
        ST_IDLE,      // waiting for a request
        ST_FAST,      // compare predicted way, mux preset to it
        ST_SLOW,      // compare the other way
        ST_SLOW_RSP,  // deliver word found in the other way
        ST_FETCH,     // block request outstanding
        ST_FILL_RSP   // deliver word from the freshly filled line
    } wp_state_e;

endpackage

// File: rtl/wp_way_store.sv
module wp_way_store #(
    parameter  int SETS  = 64,
    parameter  int TAG_W = 22,
    parameter  int BLK_W = 128,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [1:0]                 rd_valid,
    output logic [1:0][TAG_W-1:0]      rd_tag,
    output logic [1:0][BLK_W-1:0]      rd_data,
    input  logic                       wr_en,
    input  logic                       wr_way,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [TAG_W-1:0]           wr_tag,
    input  logic [BLK_W-1:0]           wr_data
);

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [SETS-1:0]  vld_d, vld_q;
        logic [TAG_W-1:0] tag_q [SETS];
        logic [BLK_W-1:0] dat_q [SETS];
        logic             sel_w;

        assign sel_w = wr_en && (wr_way == 1'(w));

        always_comb begin
            vld_d = vld_q;
            if (sel_w) begin
                vld_d[wr_idx] = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q <= '0;
            end else begin
                vld_q <= vld_d;
            end
        end

        // Tag and data need no reset: valid bit guards them
        always_ff @(posedge clk) begin
            if (sel_w) begin
                tag_q[wr_idx] <= wr_tag;
                dat_q[wr_idx] <= wr_data;
            end
        end

        assign rd_valid[w] = vld_q[rd_idx];
        assign rd_tag[w]   = tag_q[rd_idx];
        assign rd_data[w]  = dat_q[rd_idx];
    end

endmodule

// File: rtl/wp_way_pred.sv
module wp_way_pred #(
    parameter  int SETS  = 64,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_way,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_way
);

    logic [SETS-1:0] guess_d, guess_q;

    always_comb begin
        guess_d = guess_q;
        if (upd_en) begin
            guess_d[upd_idx] = upd_way;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            guess_q <= '0;
        end else begin
            guess_q <= guess_d;
        end
    end

    assign rd_way = guess_q[rd_idx];

endmodule

// File: rtl/wp_lookup_ctrl.sv
module wp_lookup_ctrl
    import wp_cache_pkg::*;
#(
    parameter int TAG_W  = 22,
    parameter int IDX_W  = 6,
    parameter int WSEL_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [TAG_W-1:0]      req_tag,
    input  logic [IDX_W-1:0]      req_idx,
    input  logic [WSEL_W-1:0]     req_wsel,
    output logic                  req_ready,
    output logic [TAG_W-1:0]      cur_tag,
    output logic [IDX_W-1:0]      cur_idx,
    output logic [WSEL_W-1:0]     cur_wsel,
    input  logic                  pred_way,
    input  logic [1:0]            way_valid,
    input  logic [1:0][TAG_W-1:0] way_tag,
    output logic                  sel_way,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic                  mem_req,
    input  logic                  mem_ack,
    output logic                  fill_en,
    output logic                  fill_way,
    output logic                  pred_upd_en,
    output logic                  pred_upd_way
);

    typedef struct packed {
        wp_state_e         state;
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [WSEL_W-1:0] wsel;
        logic              way;   // way under test in SLOW, victim in FETCH
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  cmp_way;
    logic  tag_match;

    // One comparator shared by both lookup phases
    assign cmp_way   = (r_q.state == ST_FAST) ? pred_way : r_q.way;
    assign tag_match = way_valid[cmp_way] && (way_tag[cmp_way] == r_q.tag);

    always_comb begin
        r_d          = r_q;
        req_ready    = 1'b0;
        rsp_valid    = 1'b0;
        rsp_hit      = 1'b0;
        mem_req      = 1'b0;
        fill_en      = 1'b0;
        pred_upd_en  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    r_d.state = ST_FAST;
                    r_d.tag   = req_tag;
                    r_d.idx   = req_idx;
                    r_d.wsel  = req_wsel;
                end
            end
            ST_FAST: begin
                if (tag_match) begin
                    rsp_valid = 1'b1;
                    rsp_hit   = 1'b1;
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.way   = ~pred_way;
                    r_d.state = ST_SLOW;
                end
            end
            ST_SLOW: begin
                if (tag_match) begin
                    pred_upd_en = 1'b1;
                    r_d.state   = ST_SLOW_RSP;
                end else begin
                    r_d.state   = ST_FETCH;
                end
            end
            ST_SLOW_RSP: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                r_d.state = ST_IDLE;
            end
            ST_FETCH: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    fill_en     = 1'b1;
                    pred_upd_en = 1'b1;
                    r_d.state   = ST_FILL_RSP;
                end
            end
            ST_FILL_RSP: begin
                rsp_valid = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cur_tag      = r_q.tag;
    assign cur_idx      = r_q.idx;
    assign cur_wsel     = r_q.wsel;
    assign sel_way      = cmp_way;
    assign fill_way     = r_q.way;
    assign pred_upd_way = r_q.way;

endmodule

// File: rtl/wp_cache.sv
module wp_cache #(
    parameter int ADDR_W    = 32,
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 4,
    parameter int SETS      = 64
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       req_valid,
    input  logic [ADDR_W-1:0]                          req_addr,
    output logic                                       req_ready,
    output logic                                       rsp_valid,
    output logic                                       rsp_hit,
    output logic [WORD_W-1:0]                          rsp_data,
    output logic                                       mem_req,
    output logic [ADDR_W-$clog2(WORD_W*BLK_WORDS/8)-1:0] mem_addr,
    input  logic                                       mem_ack,
    input  logic [WORD_W*BLK_WORDS-1:0]                mem_data
);

    localparam int BLK_W  = WORD_W * BLK_WORDS;
    localparam int OFF_W  = $clog2(BLK_W / 8);
    localparam int BYTE_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = $clog2(BLK_WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int BA_W   = ADDR_W - OFF_W;

    logic [TAG_W-1:0]      cur_tag;
    logic [IDX_W-1:0]      cur_idx;
    logic [WSEL_W-1:0]     cur_wsel;
    logic                  pred_way;
    logic [1:0]            way_valid;
    logic [1:0][TAG_W-1:0] way_tag;
    logic [1:0][BLK_W-1:0] way_data;
    logic                  sel_way;
    logic                  fill_en, fill_way;
    logic                  pred_upd_en, pred_upd_way;
    logic [BLK_W-1:0]      blk_sel;
    logic                  unused_byte_bits;

    assign unused_byte_bits = ^req_addr[BYTE_W-1:0];

    wp_lookup_ctrl #(
        .TAG_W (TAG_W),
        .IDX_W (IDX_W),
        .WSEL_W(WSEL_W)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_tag     (req_addr[ADDR_W-1 -: TAG_W]),
        .req_idx     (req_addr[OFF_W +: IDX_W]),
        .req_wsel    (req_addr[BYTE_W +: WSEL_W]),
        .req_ready   (req_ready),
        .cur_tag     (cur_tag),
        .cur_idx     (cur_idx),
        .cur_wsel    (cur_wsel),
        .pred_way    (pred_way),
        .way_valid   (way_valid),
        .way_tag     (way_tag),
        .sel_way     (sel_way),
        .rsp_valid   (rsp_valid),
        .rsp_hit     (rsp_hit),
        .mem_req     (mem_req),
        .mem_ack     (mem_ack),
        .fill_en     (fill_en),
        .fill_way    (fill_way),
        .pred_upd_en (pred_upd_en),
        .pred_upd_way(pred_upd_way)
    );

    wp_way_store #(
        .SETS (SETS),
        .TAG_W(TAG_W),
        .BLK_W(BLK_W)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (cur_idx),
        .rd_valid(way_valid),
        .rd_tag  (way_tag),
        .rd_data (way_data),
        .wr_en   (fill_en),
        .wr_way  (fill_way),
        .wr_idx  (cur_idx),
        .wr_tag  (cur_tag),
        .wr_data (mem_data)
    );

    wp_way_pred #(
        .SETS(SETS)
    ) pred_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (cur_idx),
        .rd_way (pred_way),
        .upd_en (pred_upd_en),
        .upd_idx(cur_idx),
        .upd_way(pred_upd_way)
    );

    // Block mux follows the predicted way in the first cycle
    assign blk_sel = way_data[sel_way];

    always_comb begin
        rsp_data = '0;
        for (int i = 0; i < BLK_WORDS; i++) begin
            if (cur_wsel == WSEL_W'(i)) begin
                rsp_data = blk_sel[i*WORD_W +: WORD_W];
            end
        end
    end

    assign mem_addr = {cur_tag, cur_idx};

endmodule

// File: rtl/wp_cache_chk.sv
module wp_cache_chk #(
    parameter int BA_W = 28
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            mem_req,
    input logic [BA_W-1:0] mem_addr,
    input logic            mem_ack
);

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    p_rsp_not_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    p_hit_needs_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    p_fetch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    p_fetch_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !rsp_valid && !req_ready);

    p_fill_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> rsp_valid && !rsp_hit && !mem_req);

    p_idle_after_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

endmodule

bind wp_cache wp_cache_chk #(.BA_W(BA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .rsp_hit  (rsp_hit),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack)
);

// File: tb/wp_cache_tb_top.sv
`timescale 1ns/1ps
module wp_cache_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_addr = '0;
    logic         req_ready;
    logic         rsp_valid;
    logic         rsp_hit;
    logic [31:0]  rsp_data;
    logic         mem_req;
    logic [27:0]  mem_addr;
    logic         mem_ack = 1'b0;
    logic [127:0] mem_data = '0;

    int total = 0;
    int bad   = 0;

    // Reference state: per set, per way
    bit          m_vld [64][2];
    int unsigned m_tag [64][2];
    bit          m_pred[64];

    always #2 clk = ~clk;

    wp_cache dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_data(rsp_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_data(mem_data)
    );

    function automatic logic [31:0] word_of(logic [27:0] ba, int w);
        logic [31:0] v;
        v = ({4'h0, ba} * 32'd7) + (32'(w) * 32'h0101_1111);
        return v ^ 32'h5A00_00C3;
    endfunction

    function automatic logic [127:0] blk_of(logic [27:0] ba);
        logic [127:0] b;
        for (int w = 0; w < 4; w++) b[w*32 +: 32] = word_of(ba, w);
        return b;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One read access; called at a negedge with the controller idle
    task automatic access(logic [31:0] addr, int ack_dly, bit noise, string lbl);
        int          idx   = int'(addr[9:4]);
        int unsigned tag   = 32'(addr[31:10]);
        logic [27:0] ba    = addr[31:4];
        int          w     = int'(addr[3:2]);
        int          lat;
        int          ack_n = -1;
        bit          exp_hit;
        bit          p     = m_pred[idx];
        bit          o     = !p;
        if (m_vld[idx][p] && m_tag[idx][p] == tag) begin
            lat = 1; exp_hit = 1'b1;
        end else if (m_vld[idx][o] && m_tag[idx][o] == tag) begin
            lat = 3; exp_hit = 1'b1; m_pred[idx] = o;
        end else begin
            lat = 4 + ack_dly; exp_hit = 1'b0; ack_n = 3 + ack_dly;
            m_vld[idx][o] = 1'b1; m_tag[idx][o] = tag; m_pred[idx] = o;
        end
        check(req_ready == 1'b1, "R10 ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_addr  = addr;
        for (int n = 1; n <= lat + 1; n++) begin
            @(negedge clk);
            check(rsp_valid == (n == lat), {lbl, " rsp_valid timing"}, 64'(rsp_valid), 64'(n == lat));
            if (n == lat) begin
                check(rsp_hit == exp_hit, {lbl, " R7 rsp_hit"}, 64'(rsp_hit), 64'(exp_hit));
                check(rsp_data == word_of(ba, w), {lbl, " R8 rsp_data"}, 64'(rsp_data), 64'(word_of(ba, w)));
            end
            check(mem_req == (ack_n >= 0 && n >= 3 && n <= ack_n), {lbl, " R6 mem_req"},
                  64'(mem_req), 64'(ack_n >= 0 && n >= 3 && n <= ack_n));
            if (ack_n >= 0 && n >= 3 && n <= ack_n)
                check(mem_addr == ba, "R6 mem_addr", 64'(mem_addr), 64'(ba));
            check(req_ready == (n == lat + 1), {lbl, " R2 R10 req_ready"}, 64'(req_ready), 64'(n == lat + 1));
            // drive for this cycle
            if (n == 1 && lat > 1 && noise) begin
                req_valid = 1'b1;                      // R2: ignored while busy
                req_addr  = ~addr;
            end else if (n == 1 || n == lat) begin
                req_valid = 1'b0;
            end
            if (n == ack_n) begin
                mem_ack  = 1'b1;
                mem_data = blk_of(ba);
            end else if (noise && n == 2) begin
                mem_ack  = 1'b1;                       // R11: stray acknowledge
                mem_data = {4{32'hDEAD_BEEF}};
            end else begin
                mem_ack  = 1'b0;
            end
        end
    endtask

    function automatic logic [31:0] mk(int unsigned tag, int set, int w);
        return {tag[21:0], set[5:0], w[1:0], 2'b00};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed = 32'h1234_5678;
        int sets[4] = '{5, 9, 63, 0};
        int unsigned tags[4] = '{1, 2, 3, 32'h3F_FFFF};
        for (int s = 0; s < 64; s++) begin
            m_pred[s] = 1'b0;
            for (int k = 0; k < 2; k++) begin m_vld[s][k] = 1'b0; m_tag[s][k] = 0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
        check(mem_req == 1'b0, "R1 reset mem_req", 64'(mem_req), 64'd0);

        access(mk(1, 5, 0), 0, 1'b0, "R1 R9 cold miss fills way1");
        access(mk(1, 5, 3), 0, 1'b0, "R3 fast hit");
        access(mk(2, 5, 1), 2, 1'b1, "R9 second miss fills way0");
        access(mk(2, 5, 2), 0, 1'b0, "R3 fast hit way0");
        access(mk(1, 5, 2), 0, 1'b1, "R4 slow hit");
        access(mk(1, 5, 1), 0, 1'b0, "R5 flipped prediction");
        access(mk(3, 5, 0), 1, 1'b1, "R7 evict non-predicted");
        access(mk(2, 5, 0), 3, 1'b0, "R9 evicted line misses");
        access(mk(1, 5, 0), 0, 1'b0, "R7 evicted line misses");
        access(mk(2, 5, 3), 0, 1'b0, "R4 slow hit after refills");
        access(mk(7, 63, 1), 5, 1'b1, "R11 stray ack ignored");

        for (int i = 0; i < 150; i++) begin
            int s, t, w, d;
            seed = seed * 32'd1103515245 + 32'd12345;
            s = int'(seed[25:24]); t = int'(seed[21:20]); w = int'(seed[17:16]);
            d = int'(seed[13:12]);
            access(mk(tags[t], sets[s], w), d, seed[9], "R8 mixed traffic");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule